// File: doc/BRIEF.md
# Scanline Interrupt Timer

This block raises an interrupt after a programmed number of video scanlines. The CPU reaches it by writing to four registers: two nibble-wide halves of an 8-bit reload value, a 2-bit control word, and an acknowledge slot. A one-cycle pulse on `line_tick` marks the end of each scanline. While counting is enabled, each pulse moves an 8-bit counter up by one. When a pulse arrives with the counter at 0xFF, the interrupt line goes high and the counter restarts from one past the reload value.

Software programs a countdown in a fixed sequence. It writes the reload value, then writes the control word with its upper bit set, which starts counting from the reload value. The first interrupt comes 256 − L scanlines later, where L is the reload value. Each interrupt after that comes 255 − L scanlines after the one before it. The interrupt is a level. It stays high until software clears it by writing the control word or the acknowledge slot. The acknowledge write also restores the enable bit from a saved copy kept in control bit 0.

Top module: `scanline_irq_timer`

## Requirements
- R1: Reset (`rst_n` low) forces `irq` low and clears the counter, the reload value and both control bits. So after reset, a control write of 0x02 with no reload write gives the first interrupt on the 256th tick.
- R2: A write with address low bits 0x0 puts `wr_data[3:0]` into the lower nibble of the reload value. Low bits 0x1 put `wr_data[3:0]` into the upper nibble. The other nibble keeps its value in both cases.
- R3: A write with address low bits 0x2 sets control to `wr_data[1:0]` and drops `irq`. If `wr_data[1]` is 1, the counter also loads the reload value in the same cycle.
- R4: A write with address low bits 0x3 drops `irq` and copies control bit 0 into control bit 1. Control bit 0 and the counter are left unchanged.
- R5: A tick with control bit 1 set moves the counter up by one. If the counter was 0xFF, the tick instead raises `irq` and loads the reload value plus one, taken modulo 256 (0xFF reloads to 0x00).
- R6: A tick with control bit 1 clear changes neither the counter nor `irq`.
- R7: Once high, `irq` stays high until a control write, an acknowledge write or reset. Ticks and other writes do not lower it.
- R8: A register write in the same cycle as a tick takes priority, and that tick is dropped.
- R9: A write reaches a register only if `wr_addr[15:12]` is 0xF and `wr_addr[3:2]` is 0. `wr_addr[11:4]` is ignored, and `wr_addr[1:0]` picks the register. Writes to any other address have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| line_tick | input | 1 | One-cycle pulse at the end of each scanline |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-bit address, 8-bit data and a 0xF register page. With 8-bit data, a full counter cycle is at most 256 ticks, so both extremes are reached directly. A reload value of 0x00 or 0xFF needs only a few hundred cycles to show its full interval. That includes the 0xFF-to-0x00 reload wrap. With the 16-bit address, the bench can also probe the ignored middle bits, a wrong page, and nonzero bits 3:2.

// File: rtl/scanline_irq_timer.sv
module scanline_irq_timer #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [3:0] PAGE = 4'hF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              line_tick,
  output logic              irq
);
  localparam int CNT_W = 8;
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] reload;
  logic [1:0]       ctrl;

  wire       reg_hit = wr_en && (wr_addr[ADDR_W-1 -: 4] == PAGE) && (wr_addr[3:2] == 2'b00);
  wire [1:0] sel     = wr_addr[1:0];
  wire       run     = line_tick && ctrl[1] && !reg_hit;
  wire       expire  = run && (cnt == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload <= '0;
    end else if (reg_hit && sel == 2'd0) begin
      reload[3:0] <= wr_data[3:0];
    end else if (reg_hit && sel == 2'd1) begin
      reload[7:4] <= wr_data[3:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= 2'b00;
    end else if (reg_hit && sel == 2'd2) begin
      ctrl <= wr_data[1:0];
    end else if (reg_hit && sel == 2'd3) begin
      ctrl[1] <= ctrl[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (reg_hit) begin
      if (sel == 2'd2 && wr_data[1]) cnt <= reload;
    end else if (expire) begin
      cnt <= reload + 1'b1;
    end else if (run) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else if (reg_hit && sel[1]) begin
      irq <= 1'b0;
    end else if (expire) begin
      irq <= 1'b1;
    end
  end
endmodule

// File: rtl/scanline_irq_timer_chk.sv
module scanline_irq_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_addr,
  input logic [7:0]  wr_data,
  input logic        line_tick,
  input logic        irq,
  input logic [7:0]  cnt,
  input logic [7:0]  reload,
  input logic [1:0]  ctrl
);
  wire hit    = wr_en && wr_addr[15:12] == 4'hF && wr_addr[3:2] == 2'b00;
  wire wr_ctl = hit && wr_addr[1:0] == 2'd2;
  wire wr_ack = hit && wr_addr[1:0] == 2'd3;

  assert_ctl_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> !irq && ctrl == $past(wr_data[1:0]));

  assert_ack_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |=> !irq && ctrl[1] == $past(ctrl[0]) && cnt == $past(cnt));

  assert_expire_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (line_tick && !hit && ctrl[1] && cnt == 8'hFF) |=> irq && cnt == 8'($past(reload) + 8'd1));

  assert_rise_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(line_tick && ctrl[1] && cnt == 8'hFF));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (line_tick && !ctrl[1] && !hit) |=> $stable(cnt));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_ctl && !wr_ack) |=> irq);

  assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (line_tick && hit && !wr_ctl) |=> cnt == $past(cnt));
endmodule

bind scanline_irq_timer scanline_irq_timer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .line_tick(line_tick), .irq(irq), .cnt(cnt), .reload(reload), .ctrl(ctrl)
);

// File: tb/scanline_irq_timer_tb_top.sv
`timescale 1ns/1ps
module scanline_irq_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic line_tick = 1'b0;
  logic irq;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  scanline_irq_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .line_tick(line_tick), .irq(irq)
  );

  localparam logic [1:0] IDLE = 2'd0, WR = 2'd1, TK = 2'd2, WT = 2'd3;
  // {op, addr, data, expected irq, requirement id}
  localparam int NV = 23;
  localparam logic [29:0] VEC [NV] = '{
    {WR, 16'hF000, 8'h0C, 1'b0, 3'd2},
    {WR, 16'hF001, 8'hFF, 1'b0, 3'd2},
    {WR, 16'hF002, 8'h03, 1'b0, 3'd3},
    {TK, 16'h0000, 8'h00, 1'b0, 3'd5},
    {TK, 16'h0000, 8'h00, 1'b0, 3'd5},
    {TK, 16'h0000, 8'h00, 1'b0, 3'd5},
    {TK, 16'h0000, 8'h00, 1'b1, 3'd5},
    {IDLE, 16'h0000, 8'h00, 1'b1, 3'd7},
    {WR, 16'hF003, 8'h00, 1'b0, 3'd4},
    {TK, 16'h0000, 8'h00, 1'b0, 3'd5},
    {TK, 16'h0000, 8'h00, 1'b0, 3'd5},
    {TK, 16'h0000, 8'h00, 1'b1, 3'd5},
    {TK, 16'h0000, 8'h00, 1'b1, 3'd7},
    {WR, 16'hF002, 8'h01, 1'b0, 3'd3},
    {TK, 16'h0000, 8'h00, 1'b0, 3'd6},
    {TK, 16'h0000, 8'h00, 1'b0, 3'd6},
    {TK, 16'h0000, 8'h00, 1'b0, 3'd6},
    {TK, 16'h0000, 8'h00, 1'b0, 3'd6},
    {WR, 16'hF003, 8'h00, 1'b0, 3'd4},
    {TK, 16'h0000, 8'h00, 1'b0, 3'd6},
    {TK, 16'h0000, 8'h00, 1'b1, 3'd6},
    {WR, 16'hF002, 8'h00, 1'b0, 3'd3},
    {WR, 16'hF003, 8'h00, 1'b0, 3'd4}
  };

  function automatic string req_name(input logic [2:0] id);
    case (id)
      3'd2: return "R2";
      3'd3: return "R3";
      3'd4: return "R4";
      3'd5: return "R5";
      3'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic step(input logic [1:0] op, input logic [15:0] a, input logic [7:0] d);
    wr_en = op[0];
    line_tick = op[1];
    wr_addr = a;
    wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    line_tick = 1'b0;
  endtask

  task automatic check(input logic exp, input string req);
    n_chk++;
    if (irq !== exp) begin
      n_bad++;
      $display("FAIL %s: irq=%0b expected %0b at %0t", req, irq, exp, $time);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(TK, 16'h0, 8'h0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
  endtask

  initial begin
    #1ms;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    check(1'b0, "R1");

    for (int v = 0; v < NV; v++) begin
      step(VEC[v][29:28], VEC[v][27:12], VEC[v][11:4]);
      check(VEC[v][3], req_name(VEC[v][2:0]));
    end

    // R1: zero reload after reset gives a 256-tick interval
    do_reset();
    step(WR, 16'hF002, 8'h02);
    ticks(255);
    check(1'b0, "R1");
    ticks(1);
    check(1'b1, "R1");

    // R5: reload 0xFF fires at once, then wraps to 0x00
    do_reset();
    step(WR, 16'hF000, 8'hAF);
    step(WR, 16'hF001, 8'h5F);
    step(WR, 16'hF002, 8'h03);
    ticks(1);
    check(1'b1, "R5");
    step(WR, 16'hF003, 8'h00);
    check(1'b0, "R4");
    ticks(255);
    check(1'b0, "R5");
    ticks(1);
    check(1'b1, "R5");

    // R8: a tick that coincides with a register write is dropped
    step(WR, 16'hF000, 8'h0E);
    step(WR, 16'hF002, 8'h03);
    check(1'b0, "R3");
    ticks(1);
    check(1'b0, "R5");
    step(WT, 16'hF000, 8'h0E);
    check(1'b0, "R8");
    ticks(1);
    check(1'b1, "R8");

    // R9: address decoding
    step(WR, 16'hE002, 8'h00);
    check(1'b1, "R9");
    step(WR, 16'h8003, 8'h00);
    check(1'b1, "R9");
    step(WR, 16'hF004, 8'h00);
    check(1'b1, "R9");
    step(WR, 16'hF0F3, 8'h00);
    check(1'b0, "R9");
    ticks(1);
    check(1'b1, "R9");

    // R1: reset while irq is high
    rst_n = 1'b0;
    #2;
    check(1'b0, "R1");
    rst_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule